// File: doc/BRIEF.md
# Asynchronous Error Status Capture Unit

This unit collects error event strobes from the memory, cache and system-interface paths of a processor and turns them into a software-visible error log. Each detected error class has its own sticky status bit. Software clears a bit by writing a one to its position. A separate multiple-error flag records repeated serious errors. The privilege state, the faulting address and two ECC syndromes are captured for the single highest-priority event that is still outstanding.

Every cycle the event sources present a strobe vector. One address, one 9-bit data syndrome, one 4-bit tag syndrome, a privilege flag and a burst position go with it. The burst position marks which 16-byte beat of a 64-byte transfer the strobes belong to. Software reads two 64-bit words, the status word and the fault address, through a simple registered read port. It clears status through the write port. Two registered outputs come from the status: an error pin for protocol and internal faults, and a disrupting-trap request gated by an interrupt-enable input.

Top module: `err_status_unit`

## Requirements
- R1: After synchronous reset, the status word, the address word, `reg_rdata`, `err_o` and `trap_o` are all zero.
- R2: Event input `ev_stb[i]` sets status bit 33+i on the clock edge where it is accepted. The bit stays set until cleared by software, and a read never changes it. Reads give, for i: 18 protocol, 17 internal, 16 address parity, 15 tag-ECC corrected, 14 tag-ECC uncorrectable, 13 vector corrected, 12 vector uncorrectable, 11 unmapped, 10 bus error, 9 cache software-correctable, 8 cache uncorrectable, 7 copyout corrected, 6 copyout uncorrectable, 5 writeback corrected, 4 writeback uncorrectable, 3 merge corrected, 2 merge uncorrectable, 1 bus-data uncorrectable, 0 bus-data corrected.
- R3: A status write (`reg_wr` with `reg_sel`=0) clears each of bits 53, 52 and 51:33 where `reg_wdata` has a one. Writes leave the data syndrome (bits 8:0), the tag syndrome (bits 19:16) and the address word (`reg_sel`=1) unchanged. All other status bits read as zero.
- R4: When a clear and a new event hit the same status bit in one cycle, the bit stays set.
- R5: Bit 53 (multiple-error) sets when an accepted uncorrectable or software-correctable event finds its own status bit already set. It never sets from hardware-corrected events.
- R6: Uncorrectable is the highest class: i = 18, 17, 16, 14, 12, 11, 10, 8, 6, 4, 2 and 1. Index 9 is software-correctable. All others are hardware-corrected, the lowest class. Among the events of one cycle, the highest class wins, and within a class the lowest index wins. The winner loads address, both syndromes and bit 52 (privilege) when no capture is held, or when its class is strictly higher than the held capture's class.
- R7: A held capture is released when its own status bit is cleared, even if other status bits remain set. The captured values stay unchanged until the next capture.
- R8: ECC events (every index below 16 except 11 and 10) are dropped entirely when `ev_burst`=1 and `ev_beat`≠0, if an ECC event was accepted earlier in the same transfer. A transfer starts at beat 0. Dropped events set no status bit and no multiple-error flag.
- R9: `err_o` is high in the cycle after the edge that leaves status bit 51 or 50 set, and is low otherwise.
- R10: `trap_o` is high after an edge at which `int_en` was high and a trap-class status bit (indices 16 down to 0 by default) is set. It is low otherwise.
- R11: With `reg_rd` high at an edge, `reg_rdata` shows, from that edge on, the status word (`reg_sel`=0) or the zero-extended address word (`reg_sel`=1) as they stood before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_stb | input | 19 | Per-class error event strobes |
| ev_addr | input | 40 | Address of this cycle's events |
| ev_dsyn | input | 9 | Data ECC syndrome of this cycle's events |
| ev_tsyn | input | 4 | Tag ECC syndrome of this cycle's events |
| ev_priv | input | 1 | Privilege state when the events were detected |
| ev_burst | input | 1 | Events belong to a 64-byte transfer |
| ev_beat | input | 2 | 16-byte beat index within the transfer |
| int_en | input | 1 | Interrupt enable for the trap request |
| reg_sel | input | 1 | 0 status word, 1 address word |
| reg_wr | input | 1 | Write strobe (write-one-to-clear on status) |
| reg_wdata | input | 64 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 64 | Registered read data |
| err_o | output | 1 | Error pin for protocol and internal faults |
| trap_o | output | 1 | Disrupting-trap request |

## Verification
On every cycle, the assertions check four things. Sticky bits hold until a write clears them. An accepted event always leaves its bit set. The multiple-error flag never rises without a repeated serious event. A held capture keeps its address and syndromes until it is outranked or released. They also tie `err_o` to the protocol and internal bits and `trap_o` to the enable. Only the bench scenarios can show the outcomes that depend on history. These include which event's address survives a mixed sequence of classes, release of the capture while lower-priority bits remain set, tie-breaking among simultaneous events, and the dropping of later-beat ECC errors inside a transfer.

// File: rtl/err_pkg.sv
package err_pkg;
  // Priority classes for capture; numeric order is the priority order.
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_HWC  = 2'd1,
    CLS_SWC  = 2'd2,
    CLS_UNC  = 2'd3
  } err_cls_e;
endpackage

// File: rtl/err_burst_filter.sv
module err_burst_filter #(
  parameter int NUM_EVT = 19,
  parameter int BEAT_W  = 2,
  parameter logic [NUM_EVT-1:0] ECC_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_i,
  input  logic               burst_i,
  input  logic [BEAT_W-1:0]  beat_i,
  output logic [NUM_EVT-1:0] acc_o
);
  logic seen_q;
  logic drop;
  logic ecc_now;

  assign drop    = burst_i && (beat_i != '0) && seen_q;
  assign acc_o   = drop ? (ev_i & ~ECC_MASK) : ev_i;
  assign ecc_now = |(acc_o & ECC_MASK);

  always_ff @(posedge clk) begin
    if (rst)
      seen_q <= 1'b0;
    else if (burst_i)
      seen_q <= (beat_i == '0) ? ecc_now : (seen_q | ecc_now);
    else
      seen_q <= 1'b0;
  end

  // R8: an ECC event accepted inside a transfer blocks ECC events on the following later beat
  assert_burst_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (burst_i && ecc_now) |=> ((burst_i && beat_i != '0) -> ((acc_o & ECC_MASK) == '0)));
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
  parameter int NUM_EVT = 19,
  parameter logic [NUM_EVT-1:0] SERIOUS_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] acc_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               clr_me_i,
  output logic [NUM_EVT-1:0] sticky_q,
  output logic [NUM_EVT-1:0] sticky_nx,
  output logic               me_q
);
  logic me_set;

  assign sticky_nx = (sticky_q & ~clr_i) | acc_i;
  assign me_set    = |(acc_i & sticky_q & SERIOUS_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      me_q     <= 1'b0;
    end else begin
      sticky_q <= sticky_nx;
      me_q     <= (me_q & ~clr_me_i) | me_set;
    end
  end

  // R2: bits not being cleared keep their value
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & $past(sticky_q & ~clr_i)) == $past(sticky_q & ~clr_i)));
  // R4: an accepted event always leaves its bit set, whatever the write did
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sticky_q & $past(acc_i)) == $past(acc_i)));
  // R5: without a repeated serious event the flag cannot rise
  assert_me_serious_R5: assert property (@(posedge clk) disable iff (rst)
    (!me_q && ((acc_i & sticky_q & SERIOUS_MASK) == '0)) |=> !me_q);
endmodule

// File: rtl/err_winner.sv
module err_winner
  import err_pkg::*;
#(
  parameter int NUM_EVT = 19,
  parameter logic [NUM_EVT-1:0] UNC_MASK = '0,
  parameter logic [NUM_EVT-1:0] SWC_MASK = '0,
  localparam int IDX_W = $clog2(NUM_EVT)
) (
  input  logic [NUM_EVT-1:0] acc_i,
  output logic               win_any,
  output err_cls_e           win_cls,
  output logic [IDX_W-1:0]   win_idx
);
  function automatic err_cls_e cls_of(input int i);
    if (UNC_MASK[i]) return CLS_UNC;
    if (SWC_MASK[i]) return CLS_SWC;
    return CLS_HWC;
  endfunction

  // Walk downward so that, within a class, the lowest index is taken last.
  always_comb begin
    win_any = 1'b0;
    win_cls = CLS_NONE;
    win_idx = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (acc_i[i] && (cls_of(i) >= win_cls)) begin
        win_any = 1'b1;
        win_cls = cls_of(i);
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/err_capture.sv
module err_capture
  import err_pkg::*;
#(
  parameter int NUM_EVT = 19,
  parameter int ADDR_W  = 40,
  parameter int DSYN_W  = 9,
  parameter int TSYN_W  = 4,
  localparam int IDX_W  = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_any,
  input  err_cls_e           win_cls,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [NUM_EVT-1:0] sticky_nx,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DSYN_W-1:0]  dsyn_i,
  input  logic [TSYN_W-1:0]  tsyn_i,
  input  logic               priv_i,
  input  logic               clr_priv_i,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DSYN_W-1:0]  dsyn_q,
  output logic [TSYN_W-1:0]  tsyn_q,
  output logic               priv_q
);
  err_cls_e         lock_cls;
  logic [IDX_W-1:0] lock_idx;
  logic             held_live;
  logic             take;

  assign held_live = (lock_cls != CLS_NONE) && sticky_nx[lock_idx];
  assign take      = win_any && (!held_live || (win_cls > lock_cls));

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_cls <= CLS_NONE;
      lock_idx <= '0;
      addr_q   <= '0;
      dsyn_q   <= '0;
      tsyn_q   <= '0;
      priv_q   <= 1'b0;
    end else if (take) begin
      lock_cls <= win_cls;
      lock_idx <= win_idx;
      addr_q   <= addr_i;
      dsyn_q   <= dsyn_i;
      tsyn_q   <= tsyn_i;
      priv_q   <= priv_i;
    end else begin
      if (!held_live) lock_cls <= CLS_NONE;
      if (clr_priv_i) priv_q <= 1'b0;
    end
  end

  // R6: a live capture is only replaced by a strictly higher class
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (held_live && !(win_any && win_cls > lock_cls)) |=> ($stable(addr_q) && $stable(dsyn_q) && $stable(tsyn_q)));
  // R7: releasing the held bit unlocks without touching the captured values
  assert_unlock_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_cls != CLS_NONE && !sticky_nx[lock_idx] && !win_any) |=> (lock_cls == CLS_NONE && $stable(addr_q)));
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
  import err_pkg::*;
#(
  parameter int NUM_EVT = 19,
  parameter int ADDR_W  = 40,
  parameter int DSYN_W  = 9,
  parameter int TSYN_W  = 4,
  parameter int BEAT_W  = 2,
  parameter logic [NUM_EVT-1:0] UNC_MASK  = 19'b111_0101_1101_0101_0110,
  parameter logic [NUM_EVT-1:0] SWC_MASK  = 19'b000_0000_0010_0000_0000,
  parameter logic [NUM_EVT-1:0] ECC_MASK  = 19'b000_1111_0011_1111_1111,
  parameter logic [NUM_EVT-1:0] PIN_MASK  = 19'b110_0000_0000_0000_0000,
  parameter logic [NUM_EVT-1:0] TRAP_MASK = 19'b001_1111_1111_1111_1111
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] ev_stb,
  input  logic [ADDR_W-1:0]  ev_addr,
  input  logic [DSYN_W-1:0]  ev_dsyn,
  input  logic [TSYN_W-1:0]  ev_tsyn,
  input  logic               ev_priv,
  input  logic               ev_burst,
  input  logic [BEAT_W-1:0]  ev_beat,
  input  logic               int_en,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [63:0]        reg_wdata,
  input  logic               reg_rd,
  output logic [63:0]        reg_rdata,
  output logic               err_o,
  output logic               trap_o
);
  localparam int REG_W      = 64;
  localparam int STICKY_LSB = 33;
  localparam int PRIV_BIT   = STICKY_LSB + NUM_EVT;
  localparam int ME_BIT     = PRIV_BIT + 1;
  localparam int TSYN_LSB   = 16;
  localparam int IDX_W      = $clog2(NUM_EVT);
  localparam logic [NUM_EVT-1:0] SERIOUS_MASK = UNC_MASK | SWC_MASK;

  logic [NUM_EVT-1:0] acc;
  logic [NUM_EVT-1:0] clr;
  logic [NUM_EVT-1:0] sticky_q;
  logic [NUM_EVT-1:0] sticky_nx;
  logic               me_q;
  logic               status_wr;
  logic               win_any;
  err_cls_e           win_cls;
  logic [IDX_W-1:0]   win_idx;
  logic [ADDR_W-1:0]  addr_q;
  logic [DSYN_W-1:0]  dsyn_q;
  logic [TSYN_W-1:0]  tsyn_q;
  logic               priv_q;
  logic [REG_W-1:0]   status_word;
  logic               wdata_unused;

  assign status_wr    = reg_wr && !reg_sel;
  assign clr          = status_wr ? reg_wdata[STICKY_LSB +: NUM_EVT] : '0;
  assign wdata_unused = ^{reg_wdata[REG_W-1:ME_BIT+1], reg_wdata[STICKY_LSB-1:0]};

  err_burst_filter #(.NUM_EVT(NUM_EVT), .BEAT_W(BEAT_W), .ECC_MASK(ECC_MASK)) i_filter (
    .clk(clk), .rst(rst), .ev_i(ev_stb), .burst_i(ev_burst), .beat_i(ev_beat), .acc_o(acc));

  err_sticky_bank #(.NUM_EVT(NUM_EVT), .SERIOUS_MASK(SERIOUS_MASK)) i_bank (
    .clk(clk), .rst(rst), .acc_i(acc), .clr_i(clr), .clr_me_i(status_wr && reg_wdata[ME_BIT]),
    .sticky_q(sticky_q), .sticky_nx(sticky_nx), .me_q(me_q));

  err_winner #(.NUM_EVT(NUM_EVT), .UNC_MASK(UNC_MASK), .SWC_MASK(SWC_MASK)) i_winner (
    .acc_i(acc), .win_any(win_any), .win_cls(win_cls), .win_idx(win_idx));

  err_capture #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DSYN_W(DSYN_W), .TSYN_W(TSYN_W)) i_capture (
    .clk(clk), .rst(rst), .win_any(win_any), .win_cls(win_cls), .win_idx(win_idx),
    .sticky_nx(sticky_nx), .addr_i(ev_addr), .dsyn_i(ev_dsyn), .tsyn_i(ev_tsyn),
    .priv_i(ev_priv), .clr_priv_i(status_wr && reg_wdata[PRIV_BIT]),
    .addr_q(addr_q), .dsyn_q(dsyn_q), .tsyn_q(tsyn_q), .priv_q(priv_q));

  always_comb begin
    status_word                         = '0;
    status_word[ME_BIT]                 = me_q;
    status_word[PRIV_BIT]               = priv_q;
    status_word[STICKY_LSB +: NUM_EVT]  = sticky_q;
    status_word[TSYN_LSB +: TSYN_W]     = tsyn_q;
    status_word[0 +: DSYN_W]            = dsyn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      err_o     <= 1'b0;
      trap_o    <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= reg_sel ? REG_W'(addr_q) : status_word;
      err_o  <= |(sticky_nx & PIN_MASK);
      trap_o <= (|(sticky_nx & TRAP_MASK)) && int_en;
    end
  end

  // R9: the pin only stands while a protocol or internal bit is set
  assert_err_pin_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (|(sticky_q & PIN_MASK)));
  // R10: the trap request needs the enable at the edge that raised it
  assert_trap_gate_R10: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(int_en));
endmodule

// File: tb/test_err_status_unit.sv
module test_err_status_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [18:0] ev_stb;
  logic [39:0] ev_addr;
  logic [8:0]  ev_dsyn;
  logic [3:0]  ev_tsyn;
  logic        ev_priv, ev_burst, int_en, reg_sel, reg_wr, reg_rd;
  logic [1:0]  ev_beat;
  logic [63:0] reg_wdata, reg_rdata;
  logic        err_o, trap_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  err_status_unit i_err_status_unit (
    .clk(clk), .rst(rst), .ev_stb(ev_stb), .ev_addr(ev_addr), .ev_dsyn(ev_dsyn),
    .ev_tsyn(ev_tsyn), .ev_priv(ev_priv), .ev_burst(ev_burst), .ev_beat(ev_beat),
    .int_en(int_en), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .err_o(err_o), .trap_o(trap_o));

  typedef struct packed {
    logic [18:0] ev;
    logic [63:0] clr;
    logic [15:0] addr;
    logic [8:0]  dsyn;
    logic [3:0]  tsyn;
    logic        priv;
    logic [18:0] x_sticky;
    logic        x_me;
    logic        x_priv;
    logic [15:0] x_addr;
    logic [8:0]  x_dsyn;
    logic [3:0]  x_tsyn;
  } step_t;

  // Index 0 bus-data corrected, 1 bus-data uncorrectable, 3 merge corrected,
  // 8 cache uncorrectable, 9 cache software-correctable.
  localparam step_t STEPS [12] = '{
    '{19'h00001, 64'h0, 16'h0100, 9'h011, 4'h1, 1'b0, 19'h00001, 1'b0, 1'b0, 16'h0100, 9'h011, 4'h1},
    '{19'h00001, 64'h0, 16'h0200, 9'h022, 4'h2, 1'b1, 19'h00001, 1'b0, 1'b0, 16'h0100, 9'h011, 4'h1},
    '{19'h00002, 64'h0, 16'h0300, 9'h033, 4'h3, 1'b1, 19'h00003, 1'b0, 1'b1, 16'h0300, 9'h033, 4'h3},
    '{19'h00002, 64'h0, 16'h0400, 9'h044, 4'h4, 1'b0, 19'h00003, 1'b1, 1'b1, 16'h0300, 9'h033, 4'h3},
    '{19'h00200, 64'h0, 16'h0500, 9'h055, 4'h5, 1'b0, 19'h00203, 1'b1, 1'b1, 16'h0300, 9'h033, 4'h3},
    '{19'h00000, 64'h0000_0004_0000_0000, 16'h0600, 9'h066, 4'h6, 1'b0, 19'h00201, 1'b1, 1'b1, 16'h0300, 9'h033, 4'h3},
    '{19'h00008, 64'h0, 16'h0700, 9'h077, 4'h7, 1'b0, 19'h00209, 1'b1, 1'b0, 16'h0700, 9'h077, 4'h7},
    '{19'h00200, 64'h0, 16'h0800, 9'h088, 4'h8, 1'b1, 19'h00209, 1'b1, 1'b1, 16'h0800, 9'h088, 4'h8},
    '{19'h00000, 64'h0030_0002_0000_0000, 16'h0900, 9'h099, 4'h9, 1'b0, 19'h00208, 1'b0, 1'b0, 16'h0800, 9'h088, 4'h8},
    '{19'h0010A, 64'h0, 16'h0A00, 9'h0AA, 4'hA, 1'b1, 19'h0030A, 1'b0, 1'b1, 16'h0A00, 9'h0AA, 4'hA},
    '{19'h00002, 64'h0000_0004_0000_0000, 16'h0B00, 9'h0BB, 4'hB, 1'b0, 19'h0030A, 1'b1, 1'b1, 16'h0A00, 9'h0AA, 4'hA},
    '{19'h00000, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0C00, 9'h0CC, 4'hC, 1'b0, 19'h00000, 1'b0, 1'b0, 16'h0A00, 9'h0AA, 4'hA}
  };

  function automatic logic [63:0] mk_status(logic [18:0] s, logic me, logic pv, logic [3:0] t, logic [8:0] d);
    return {10'b0, me, pv, s, 13'b0, t, 7'b0, d};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    reg_sel = sel;
    reg_rd  = 1'b1;
    tick();
    v       = reg_rdata;
    reg_rd  = 1'b0;
    reg_sel = 1'b0;
  endtask

  task automatic fire(input logic [18:0] ev, input logic [15:0] a, input logic [8:0] d,
                      input logic [3:0] t, input logic pv, input logic bu, input logic [1:0] be,
                      input logic wr, input logic sel, input logic [63:0] wd);
    ev_stb = ev; ev_addr = {24'h0, a}; ev_dsyn = d; ev_tsyn = t; ev_priv = pv;
    ev_burst = bu; ev_beat = be; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    tick();
    ev_stb = '0; ev_burst = 1'b0; ev_beat = '0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, s1;
    rst = 1'b1; ev_stb = '0; ev_addr = '0; ev_dsyn = '0; ev_tsyn = '0; ev_priv = 1'b0;
    ev_burst = 1'b0; ev_beat = '0; int_en = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
    reg_wdata = '0; reg_rd = 1'b0;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;

    // R1: reset state
    chk("R1 rdata", reg_rdata, 64'h0);
    chk("R1 err_o", {63'h0, err_o}, 64'h0);
    chk("R1 trap_o", {63'h0, trap_o}, 64'h0);
    rd(1'b0, v); chk("R1 status", v, 64'h0);
    rd(1'b1, v); chk("R1 address", v, 64'h0);

    // Table walk: R2 sticky, R3 clears, R4 on step 11, R5 flag, R6 priority, R7 release
    foreach (STEPS[k]) begin
      fire(STEPS[k].ev, STEPS[k].addr, STEPS[k].dsyn, STEPS[k].tsyn, STEPS[k].priv,
           1'b0, 2'd0, STEPS[k].clr != 64'h0, 1'b0, STEPS[k].clr);
      rd(1'b0, v);
      chk($sformatf("R2 sticky step %0d", k), {45'h0, v[51:33]}, {45'h0, STEPS[k].x_sticky});
      chk($sformatf("R5 multi step %0d", k), {63'h0, v[53]}, {63'h0, STEPS[k].x_me});
      chk($sformatf("R6 priv step %0d", k), {63'h0, v[52]}, {63'h0, STEPS[k].x_priv});
      chk($sformatf("R7 syndromes step %0d", k), v,
          mk_status(STEPS[k].x_sticky, STEPS[k].x_me, STEPS[k].x_priv, STEPS[k].x_tsyn, STEPS[k].x_dsyn));
      rd(1'b1, v);
      chk($sformatf("R11 address step %0d", k), v, {48'h0, STEPS[k].x_addr});
    end

    // R2: a second read still shows the same word
    rd(1'b0, s1); rd(1'b0, v);
    chk("R2 read does not clear", v, s1);

    // R3: writes to the address word are ignored
    fire(19'h0, 16'h0, 9'h0, 4'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b1, v); chk("R3 address write ignored", v, 64'h0A00);

    // R9 / R10: error pin and trap gating
    int_en = 1'b1;
    fire(19'h40000, 16'h0E00, 9'h0, 4'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0);
    chk("R9 err_o on protocol error", {63'h0, err_o}, 64'h1);
    chk("R10 no trap for protocol error", {63'h0, trap_o}, 64'h0);
    fire(19'h00800, 16'h0E10, 9'h0, 4'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0);
    chk("R10 trap with enable", {63'h0, trap_o}, 64'h1);
    int_en = 1'b0;
    tick();
    chk("R10 trap gated off", {63'h0, trap_o}, 64'h0);
    int_en = 1'b1;
    fire(19'h0, 16'h0, 9'h0, 4'h0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R9 err_o cleared", {63'h0, err_o}, 64'h0);
    chk("R10 trap cleared", {63'h0, trap_o}, 64'h0);
    int_en = 1'b0;

    // R8: later-beat ECC errors within one transfer are dropped
    fire(19'h00001, 16'h0D00, 9'h0, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 64'h0);
    fire(19'h00002, 16'h0D10, 9'h0, 4'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 64'h0);
    fire(19'h00800, 16'h0D20, 9'h0, 4'h0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 64'h0);
    fire(19'h00001, 16'h0D30, 9'h0, 4'h0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 64'h0);
    rd(1'b0, v);
    chk("R8 dropped beats", {45'h0, v[51:33]}, 64'h801);
    chk("R8 no multi flag", {63'h0, v[53]}, 64'h0);
    rd(1'b1, v); chk("R8 address from kept event", v, 64'h0D20);
    fire(19'h00002, 16'h0D40, 9'h0, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 64'h0);
    fire(19'h00000, 16'h0D50, 9'h0, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 64'h0);
    fire(19'h00200, 16'h0D60, 9'h0, 4'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 64'h0);
    rd(1'b0, v);
    chk("R8 new transfer accepted", {45'h0, v[51:33]}, 64'hA03);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule